// File: doc/BRIEF.md
# Ring Interconnect Station

This block is one station on a one-way ring that links several clients and a memory controller. The memory controller is itself just one more station, and it can act as either initiator or target. Every station puts one register stage on the ring path, so each hop costs exactly one clock and no wire runs further than from one station to the next. The ring slot is a 36-bit word plus a valid bit and a command flag. Commands, addresses and data share the same lines.

A command word names its destination station in its top four bits. The data words that follow a command belong to that destination until the next command word appears. A station removes every word that belongs to it, hands the word to its client on a receive port, and leaves an empty slot behind. All other words pass on one cycle later, unchanged. The local client offers bursts of words on a valid/ready port. The station starts a burst only into a free slot. It then keeps the whole burst contiguous on the ring. Upstream words that arrive during the burst are parked in a small skid queue and released afterwards in their arrival order. Traffic already on the ring therefore always wins over local traffic, which gives arbitration by position with no central arbiter. The interface is the same however many stations the ring holds.

Top module: `ring_station`

## Requirements
- R1: While reset is held, ring_out_vld and rx_vld are 0.
- R2: An upstream word that does not belong to this station appears on ring_out with the same cmd flag and data exactly one cycle after it arrives, provided no local burst is active and the skid queue is empty.
- R3: A command word (cmd flag 1) whose bits [35:32] equal STATION_ID is presented on rx one cycle after arrival with rx_cmd = 1, and it is not forwarded on the ring.
- R4: A data word (cmd flag 0) belongs to the most recent command word seen on ring_in. It is captured like R3 when that command named STATION_ID, and it is forwarded when that command named any other station. Empty slots do not change the ownership.
- R5: tx_rdy is 1 outside a burst only when the skid queue is empty and the incoming slot is empty or is being captured. An accepted word appears on ring_out one cycle later with its cmd flag and data.
- R6: Once a burst has started, tx_rdy stays 1 until the word marked tx_last is accepted, so the burst leaves on consecutive cycles. A single-word burst ends at once.
- R7: Upstream words that arrive during a burst are held and then forwarded in arrival order, one per cycle after the burst, with none lost.
- R8: While the skid queue holds words, tx_rdy is 0, and new upstream words queue behind the held ones.
- R9: The client keeps tx_vld high inside a burst and sends no more than MAX_BURST words per burst, so the skid queue never overflows.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_vld | input | 1 | Upstream slot occupied |
| ring_in_cmd | input | 1 | Upstream word is a command word |
| ring_in_data | input | 36 | Upstream word |
| ring_out_vld | output | 1 | Downstream slot occupied |
| ring_out_cmd | output | 1 | Downstream word is a command word |
| ring_out_data | output | 36 | Downstream word |
| tx_vld | input | 1 | Client offers a word |
| tx_cmd | input | 1 | Offered word is a command word |
| tx_data | input | 36 | Offered word |
| tx_last | input | 1 | Offered word ends the burst |
| tx_rdy | output | 1 | Station accepts the offered word this cycle |
| rx_vld | output | 1 | Captured word is valid |
| rx_cmd | output | 1 | Captured word is a command word |
| rx_data | output | 36 | Captured word |

## Verification
The bench targets ownership tracking across an empty slot. A station that forgot ownership at a gap would let a stray data word for itself travel round the ring. The bench also offers a client word in the same cycle as a passing word and in the same cycle as a captured word. A station that got this wrong would either overwrite the passing word or waste a free slot. The burst test feeds upstream traffic into the middle of a burst. An error in the skid queue would show up as lost, reordered or interleaved words on the ring output. The bench also checks that local insertion stays blocked until the queue has drained.

// File: rtl/ring_station.sv
module ring_station #(
  parameter int STATION_ID = 2,
  parameter int ID_W       = 4,
  parameter int DW         = 36,
  parameter int MAX_BURST  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_in_vld,
  input  logic          ring_in_cmd,
  input  logic [DW-1:0] ring_in_data,
  output logic          ring_out_vld,
  output logic          ring_out_cmd,
  output logic [DW-1:0] ring_out_data,
  input  logic          tx_vld,
  input  logic          tx_cmd,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  output logic          tx_rdy,
  output logic          rx_vld,
  output logic          rx_cmd,
  output logic [DW-1:0] rx_data
);

  localparam int TGT_LSB = DW - ID_W;
  localparam int DEPTH   = MAX_BURST;
  localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW      = $clog2(DEPTH + 1);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(STATION_ID);

  logic          owns_data;
  logic          burst_on;
  logic [DW:0]   skid [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  wire is_mine_cmd = ring_in_vld && ring_in_cmd && (ring_in_data[DW-1:TGT_LSB] == MY_ID);
  wire capture     = ring_in_vld && (ring_in_cmd ? is_mine_cmd : owns_data);
  wire keep        = ring_in_vld && !capture;
  wire queue_empty = (cnt == '0);

  assign tx_rdy    = burst_on || (queue_empty && !keep);
  wire   tx_fire   = tx_vld && tx_rdy;
  wire   push      = keep && (tx_fire || !queue_empty);
  wire   pop       = !tx_fire && !queue_empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owns_data <= 1'b0;
      burst_on  <= 1'b0;
    end else begin
      if (ring_in_vld && ring_in_cmd) owns_data <= is_mine_cmd;
      if (tx_fire) burst_on <= !tx_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) skid[wr_ptr] <= {ring_in_cmd, ring_in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_out_vld  <= 1'b0;
      ring_out_cmd  <= 1'b0;
      ring_out_data <= '0;
      rx_vld        <= 1'b0;
      rx_cmd        <= 1'b0;
      rx_data       <= '0;
    end else begin
      if (tx_fire) begin
        ring_out_vld  <= 1'b1;
        ring_out_cmd  <= tx_cmd;
        ring_out_data <= tx_data;
      end else if (!queue_empty) begin
        ring_out_vld  <= 1'b1;
        ring_out_cmd  <= skid[rd_ptr][DW];
        ring_out_data <= skid[rd_ptr][DW-1:0];
      end else begin
        ring_out_vld  <= keep;
        ring_out_cmd  <= ring_in_cmd;
        ring_out_data <= ring_in_data;
      end
      rx_vld  <= capture;
      rx_cmd  <= ring_in_cmd;
      rx_data <= ring_in_data;
    end
  end

  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_cmd && ring_in_data[DW-1:TGT_LSB] != MY_ID && queue_empty && !tx_vld)
    |=> (ring_out_vld && ring_out_cmd && ring_out_data == $past(ring_in_data)));

  a_r3_capture_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_cmd && ring_in_data[DW-1:TGT_LSB] == MY_ID)
    |=> (rx_vld && rx_cmd && rx_data == $past(ring_in_data)));

  a_r5_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && tx_rdy) |=> (ring_out_vld && ring_out_data == $past(tx_data)));

  a_r6_burst_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && tx_rdy && !tx_last) |=> tx_rdy);

  a_r8_block_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_empty && !burst_on |-> !tx_rdy);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> (!push || pop));

  a_r9_burst_contig: assert property (@(posedge clk) disable iff (!rst_n)
    burst_on |-> tx_vld);

endmodule

// File: tb/tb_ring_station.sv
`timescale 1ns/1ps
module tb_ring_station;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_in_vld = 1'b0, ring_in_cmd = 1'b0;
  logic [DW-1:0] ring_in_data = '0;
  logic ring_out_vld, ring_out_cmd;
  logic [DW-1:0] ring_out_data;
  logic tx_vld = 1'b0, tx_cmd = 1'b0, tx_last = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_rdy, rx_vld, rx_cmd;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ring_station #(.STATION_ID(2), .ID_W(4), .DW(DW), .MAX_BURST(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .ring_in_vld(ring_in_vld), .ring_in_cmd(ring_in_cmd), .ring_in_data(ring_in_data),
    .ring_out_vld(ring_out_vld), .ring_out_cmd(ring_out_cmd), .ring_out_data(ring_out_data),
    .tx_vld(tx_vld), .tx_cmd(tx_cmd), .tx_data(tx_data), .tx_last(tx_last), .tx_rdy(tx_rdy),
    .rx_vld(rx_vld), .rx_cmd(rx_cmd), .rx_data(rx_data)
  );

  // {in_vld, in_cmd, in_data, exp_out_vld, exp_rx_vld}; exp data equals in data
  localparam int VN = 8;
  localparam logic [39:0] VEC [VN] = '{
    {1'b1, 1'b1, 36'h5_0000_0011, 1'b1, 1'b0},  // R2 command for station 5
    {1'b1, 1'b0, 36'h0_0000_00AA, 1'b1, 1'b0},  // R4 data owned by 5
    {1'b1, 1'b1, 36'h2_0000_0022, 1'b0, 1'b1},  // R3 command for us
    {1'b1, 1'b0, 36'h0_0000_00BB, 1'b0, 1'b1},  // R4 our data
    {1'b0, 1'b0, 36'h0,           1'b0, 1'b0},  // R4 empty slot
    {1'b1, 1'b0, 36'h0_0000_00CC, 1'b0, 1'b1},  // R4 ownership kept over gap
    {1'b1, 1'b1, 36'h7_0000_0033, 1'b1, 1'b0},  // R2 command for station 7
    {1'b1, 1'b0, 36'h0_0000_00DD, 1'b1, 1'b0}   // R4 data owned by 7
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ring(input logic v, input logic c, input logic [DW-1:0] d);
    ring_in_vld = v; ring_in_cmd = c; ring_in_data = d;
  endtask

  task automatic tx(input logic v, input logic c, input logic [DW-1:0] d, input logic l);
    tx_vld = v; tx_cmd = c; tx_data = d; tx_last = l;
  endtask

  task automatic out_is(input string req, input logic v, input logic c, input logic [DW-1:0] d);
    if (v) chk(ring_out_vld && ring_out_cmd == c && ring_out_data == d, req,
               {27'd0, ring_out_vld, ring_out_data}, {27'd0, 1'b1, d});
    else   chk(!ring_out_vld, req, {63'd0, ring_out_vld}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ring_out_vld && !rx_vld, "R1", {62'd0, ring_out_vld, rx_vld}, 64'd0);
    @(negedge clk);
    chk(!ring_out_vld && !rx_vld, "R1", {62'd0, ring_out_vld, rx_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < VN; i++) begin
      ring(VEC[i][39], VEC[i][38], VEC[i][37:2]);
      @(negedge clk);
      out_is("R2/R4 ring", VEC[i][1], VEC[i][38], VEC[i][37:2]);
      chk(rx_vld == VEC[i][0] && (!VEC[i][0] || rx_data == VEC[i][37:2]), "R3/R4 rx",
          {27'd0, rx_vld, rx_data}, {27'd0, VEC[i][0], VEC[i][37:2]});
    end
    ring(1'b0, 1'b0, '0);
    @(negedge clk);

    // R5: passing word blocks insertion; captured word frees the slot
    ring(1'b1, 1'b1, 36'h4_0000_0044);
    tx(1'b1, 1'b1, 36'h6_0000_0A01, 1'b1);
    #1 chk(!tx_rdy, "R5 blocked", {63'd0, tx_rdy}, 64'd0);
    @(negedge clk);
    out_is("R5 passing wins", 1'b1, 1'b1, 36'h4_0000_0044);
    ring(1'b1, 1'b1, 36'h2_0000_0055);
    #1 chk(tx_rdy, "R5 captured slot free", {63'd0, tx_rdy}, 64'd1);
    @(negedge clk);
    out_is("R6 single-word burst", 1'b1, 1'b1, 36'h6_0000_0A01);
    chk(rx_vld && rx_data == 36'h2_0000_0055, "R3 capture during insert", {27'd0, rx_vld, rx_data}, {28'd1, 36'h2_0000_0055});
    ring(1'b0, 1'b0, '0);
    tx(1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);

    // R6/R7/R8 burst with upstream traffic arriving mid-burst
    tx(1'b1, 1'b1, 36'h6_0000_0101, 1'b0);
    #1 chk(tx_rdy, "R5 idle ready", {63'd0, tx_rdy}, 64'd1);
    @(negedge clk);
    out_is("R5 first word", 1'b1, 1'b1, 36'h6_0000_0101);
    tx(1'b1, 1'b0, 36'h0_0000_0102, 1'b0);
    ring(1'b1, 1'b1, 36'h5_0000_0201);
    #1 chk(tx_rdy, "R6 ready in burst", {63'd0, tx_rdy}, 64'd1);
    @(negedge clk);
    out_is("R6 second word", 1'b1, 1'b0, 36'h0_0000_0102);
    tx(1'b1, 1'b0, 36'h0_0000_0103, 1'b1);
    ring(1'b1, 1'b0, 36'h0_0000_0202);
    #1 chk(tx_rdy, "R6 ready in burst", {63'd0, tx_rdy}, 64'd1);
    @(negedge clk);
    out_is("R6 last word", 1'b1, 1'b0, 36'h0_0000_0103);
    tx(1'b1, 1'b1, 36'h6_0000_0999, 1'b1);
    ring(1'b0, 1'b0, '0);
    #1 chk(!tx_rdy, "R8 blocked while draining", {63'd0, tx_rdy}, 64'd0);
    @(negedge clk);
    out_is("R7 held word 1", 1'b1, 1'b1, 36'h5_0000_0201);
    ring(1'b1, 1'b0, 36'h0_0000_0203);
    #1 chk(!tx_rdy, "R8 blocked while draining", {63'd0, tx_rdy}, 64'd0);
    @(negedge clk);
    out_is("R7 held word 2", 1'b1, 1'b0, 36'h0_0000_0202);
    ring(1'b0, 1'b0, '0);
    @(negedge clk);
    out_is("R8 queued behind", 1'b1, 1'b0, 36'h0_0000_0203);
    #1 chk(tx_rdy, "R8 ready after drain", {63'd0, tx_rdy}, 64'd1);
    @(negedge clk);
    out_is("R5 late insert", 1'b1, 1'b1, 36'h6_0000_0999);
    tx(1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    out_is("R7 ring idle", 1'b0, 1'b0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule